// File: doc/BRIEF.md
# Queued-Task Descriptor Chain Walker

This block resolves one queued storage task into the list of data segments that belong to it. It is given a table base address and a slot tag. It fetches the slot's task descriptor and passes the task's attributes out as decoded fields. It then fetches the link descriptor stored directly after the task descriptor and follows the pointer in that link to the slot's own list of transfer descriptors. For each transfer descriptor it emits one segment record (address, byte length, last flag) on a valid/ready stream to a downstream data mover.

Descriptor memory is reached through a request/response port. The walker raises a request and holds it until it is accepted. It then waits for the single matching response, which carries the first twelve bytes at the requested address, little-endian (byte k in bits 8k+7:8k). Three configuration inputs select the descriptor sizes: a large task descriptor, 64-bit addressing, and short transfer descriptors when addressing is 64-bit. The last slot of the table is reserved for direct commands and has no transfer list. The walker checks the format of every descriptor it fetches. On a format fault it stops the walk, flags an error and reports the slot tag.

Top module: `qtask_walker`

## Requirements
- R1: After `start`, the first fetch is at `baseAddr + tagIn*(T+L)`, where T is 8 bytes (16 when `cfgBigTask`=1) and L is 8 bytes (16 when `cfgWide`=1). The second fetch is at the first fetch address plus T.
- R2: The task descriptor's low 64 bits decode as follows: bit0 valid, bit1 end, bit2 interrupt, bits5:3 action, bit6 forced programming, bits10:7 context, bit11 data tag, bit12 direction, bit13 priority, bit14 queue barrier, bit15 reliable write, bits31:16 block count, bits63:32 block address. After an accepted task descriptor, `attrValid` is 1 and the attribute outputs hold those fields until the next `start`.
- R3: The first transfer descriptor is fetched at the link's address field. That field is byte offset 4, 32 bits wide when `cfgWide`=0 and 64 bits wide when `cfgWide`=1. Each following transfer descriptor is fetched one transfer size further on. The transfer size is 8 bytes when `cfgWide`=0, 16 when `cfgWide`=1, and 12 when `cfgWide`=1 and `cfgShortXfer`=1.
- R4: Each valid transfer descriptor (bit0=1, action bits5:3 = 4) produces one segment. The segment address is the field at byte offset 4, sized as in R3. The length is bits31:16 and `segLast` is bit1 (end). The record is held stable while `segValid`=1 and `segReady`=0, and the walk ends after the handshake of the segment with `segLast`=1.
- R5: For the top tag (NUM_SLOTS-1) a link descriptor with valid=0 and end=1 ends the walk without an error. No transfer fetch and no segment follow.
- R6: On any other tag, a link descriptor that is not valid=1 with action 6 ends the walk with `err`=1 and `errTag` equal to the tag, and emits no segment. On the top tag, any link other than valid=0 with end=1 does the same.
- R7: A transfer descriptor with valid=0 or with an action other than 4 ends the walk with `err`=1 and `errTag` equal to the tag. Segments already handed over remain, and no further segment follows.
- R8: At most one fetch is outstanding at a time. A request holds its address until `memReqReady`, and the walker issues the next request only after the response has arrived.
- R9: After reset, `busy`, `done`, `err`, `attrValid`, `memReqValid` and `segValid` are 0. `busy` rises only after `start` while idle, and every walk ends with `done` high for exactly one cycle.
- R10: A task descriptor with valid=0 or an action other than 5 ends the walk with `err`=1 after one fetch, and `attrValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken when idle) |
| tagIn | input | TAG_W | Slot tag to walk |
| baseAddr | input | ADDR_W | Slot table base address |
| cfgBigTask | input | 1 | Task descriptor is 16 bytes |
| cfgWide | input | 1 | 64-bit addressing mode |
| cfgShortXfer | input | 1 | 12-byte transfer descriptors in 64-bit mode |
| memReqValid | output | 1 | Descriptor fetch request |
| memReqAddr | output | ADDR_W | Fetch byte address |
| memReqReady | input | 1 | Request accepted |
| memRspValid | input | 1 | Fetch response present |
| memRspData | input | 96 | Twelve bytes from the fetch address, little-endian |
| segValid | output | 1 | Segment record valid |
| segAddr | output | ADDR_W | Segment data address |
| segLen | output | 16 | Segment byte length |
| segLast | output | 1 | Last segment of the task |
| segReady | input | 1 | Downstream accepts the segment |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Last walk stopped on a format fault |
| errTag | output | TAG_W | Tag of the faulted walk |
| attrValid | output | 1 | Task attributes are valid |
| taskBlkCnt | output | 16 | Block count |
| taskBlkAddr | output | 32 | Block address |
| taskCtx | output | 4 | Context ID |
| taskDir | output | 1 | Data direction |
| taskPrio | output | 1 | Priority |
| taskRelWr | output | 1 | Reliable write |
| taskForced | output | 1 | Forced programming |
| taskDataTag | output | 1 | Data tag |
| taskQbar | output | 1 | Queue barrier |
| taskIntr | output | 1 | Interrupt on completion |

## Verification
The hardest case to reach is a fault part-way through a transfer list: a segment has already left, and a later descriptor turns out to be malformed. It is also hard to show that bytes outside the addressed field are never used as address bits. The bench builds each slot table in its memory model. It corrupts only the second transfer descriptor of a three-segment list. In 32-bit mode it places the next descriptor's attribute word, or a filler word of ones, directly after each address field. The memory model varies its acceptance and response latency, and the sink varies `segReady`, so that held requests and held segments occur in every configuration.

// File: rtl/qtw_pkg.sv
package qtw_pkg;

  // widest slice of a descriptor the walker ever needs: 4 attr bytes + 8 address bytes
  localparam int RSP_W = 96;
  localparam int LEN_W = 16;

  localparam logic [2:0] ACT_XFER = 3'd4;
  localparam logic [2:0] ACT_TASK = 3'd5;
  localparam logic [2:0] ACT_LINK = 3'd6;

  typedef struct packed {
    logic       vld;
    logic       fin;
    logic [2:0] act;
  } hdr_t;

  typedef struct packed {
    logic ldStart;
    logic ldTask;
    logic ldLink;
    logic ldSeg;
    logic advSeg;
    logic setErr;
  } strobe_t;

  typedef struct packed {
    logic [31:0] blkAddr;
    logic [15:0] blkCnt;
    logic        relWr;
    logic        qbar;
    logic        prio;
    logic        dir;
    logic        dataTag;
    logic [3:0]  ctx;
    logic        forced;
    logic        intr;
  } attr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_TREQ, S_TWAIT, S_LREQ, S_LWAIT, S_XREQ, S_XWAIT, S_SEG, S_DONE
  } state_t;

  function automatic hdr_t hdrOf(input logic [RSP_W-1:0] d);
    hdr_t h;
    h.vld = d[0];
    h.fin = d[1];
    h.act = d[5:3];
    return h;
  endfunction

endpackage

// File: rtl/qtw_ctrl.sv
module qtw_ctrl
  import qtw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  hdr_t    hdr,
  input  logic    isDcmd,
  input  logic    segReady,
  input  logic    segLastQ,
  output strobe_t stb,
  output logic    memReqValid,
  output logic    segValid,
  output logic    busy,
  output logic    done
);

  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    memReqValid = 1'b0;
    segValid    = 1'b0;
    done        = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.ldStart = 1'b1;
          stateNxt    = S_TREQ;
        end
      end
      S_TREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = S_TWAIT;
      end
      S_TWAIT: begin
        if (memRspValid) begin
          if (hdr.vld && hdr.act == ACT_TASK) begin
            stb.ldTask = 1'b1;
            stateNxt   = S_LREQ;
          end else begin
            stb.setErr = 1'b1;
            stateNxt   = S_DONE;
          end
        end
      end
      S_LREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = S_LWAIT;
      end
      S_LWAIT: begin
        if (memRspValid) begin
          if (isDcmd) begin
            stb.setErr = !(!hdr.vld && hdr.fin);
            stateNxt   = S_DONE;
          end else if (hdr.vld && hdr.act == ACT_LINK) begin
            stb.ldLink = 1'b1;
            stateNxt   = S_XREQ;
          end else begin
            stb.setErr = 1'b1;
            stateNxt   = S_DONE;
          end
        end
      end
      S_XREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = S_XWAIT;
      end
      S_XWAIT: begin
        if (memRspValid) begin
          if (hdr.vld && hdr.act == ACT_XFER) begin
            stb.ldSeg = 1'b1;
            stateNxt  = S_SEG;
          end else begin
            stb.setErr = 1'b1;
            stateNxt   = S_DONE;
          end
        end
      end
      S_SEG: begin
        segValid = 1'b1;
        if (segReady) begin
          if (segLastQ) begin
            stateNxt = S_DONE;
          end else begin
            stb.advSeg = 1'b1;
            stateNxt   = S_XREQ;
          end
        end
      end
      S_DONE: begin
        done     = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/qtw_data.sv
module qtw_data
  import qtw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NUM_SLOTS = 32,
  localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              cfgBigTask,
  input  logic              cfgWide,
  input  logic              cfgShortXfer,
  input  logic [RSP_W-1:0]  memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output hdr_t              hdr,
  output logic              isDcmd,
  output logic [TAG_W-1:0]  curTag,
  output logic [ADDR_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              segLast,
  output logic              err,
  output logic [TAG_W-1:0]  errTag,
  output logic              attrValid,
  output attr_t             attr
);

  localparam logic [TAG_W-1:0] DCMD_TAG = TAG_W'(NUM_SLOTS - 1);

  logic [ADDR_W-1:0] curAddr;
  logic [TAG_W-1:0]  tagQ;
  logic              bigQ, wideQ, shortQ;

  // slot stride chosen from the configuration presented with start
  logic [5:0]        strideIn;
  logic [ADDR_W-1:0] slotAddr;
  assign strideIn = (cfgBigTask ? 6'd16 : 6'd8) + (cfgWide ? 6'd16 : 6'd8);
  assign slotAddr = baseAddr + ADDR_W'(tagIn) * ADDR_W'(strideIn);

  // descriptor sizes of the walk in progress
  logic [4:0] taskLen, xferLen;
  assign taskLen = bigQ ? 5'd16 : 5'd8;
  assign xferLen = !wideQ ? 5'd8 : (shortQ ? 5'd12 : 5'd16);

  // pointer field at byte offset 4, sized by the addressing mode
  logic [63:0]       ptr64;
  logic [ADDR_W-1:0] ptrAddr;
  assign ptr64 = wideQ ? memRspData[95:32] : {32'b0, memRspData[63:32]};

  generate
    if (ADDR_W > 64) begin : g_ptrWide
      assign ptrAddr = {{(ADDR_W-64){1'b0}}, ptr64};
    end else if (ADDR_W == 64) begin : g_ptrEq
      assign ptrAddr = ptr64;
    end else begin : g_ptrNarrow
      assign ptrAddr = ptr64[ADDR_W-1:0];
    end
  endgenerate

  attr_t attrD;
  always_comb begin
    attrD.blkAddr = memRspData[63:32];
    attrD.blkCnt  = memRspData[31:16];
    attrD.relWr   = memRspData[15];
    attrD.qbar    = memRspData[14];
    attrD.prio    = memRspData[13];
    attrD.dir     = memRspData[12];
    attrD.dataTag = memRspData[11];
    attrD.ctx     = memRspData[10:7];
    attrD.forced  = memRspData[6];
    attrD.intr    = memRspData[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      tagQ      <= '0;
      bigQ      <= 1'b0;
      wideQ     <= 1'b0;
      shortQ    <= 1'b0;
      attr      <= '0;
      attrValid <= 1'b0;
      segAddr   <= '0;
      segLen    <= '0;
      segLast   <= 1'b0;
      err       <= 1'b0;
      errTag    <= '0;
    end else begin
      if (stb.ldStart) begin
        curAddr   <= slotAddr;
        tagQ      <= tagIn;
        bigQ      <= cfgBigTask;
        wideQ     <= cfgWide;
        shortQ    <= cfgShortXfer;
        attrValid <= 1'b0;
        err       <= 1'b0;
      end
      if (stb.ldTask) begin
        attr      <= attrD;
        attrValid <= 1'b1;
        curAddr   <= curAddr + ADDR_W'(taskLen);
      end
      if (stb.ldLink) curAddr <= ptrAddr;
      if (stb.ldSeg) begin
        segAddr <= ptrAddr;
        segLen  <= memRspData[31:16];
        segLast <= memRspData[1];
      end
      if (stb.advSeg) curAddr <= curAddr + ADDR_W'(xferLen);
      if (stb.setErr) begin
        err    <= 1'b1;
        errTag <= tagQ;
      end
    end
  end

  assign memReqAddr = curAddr;
  assign hdr        = hdrOf(memRspData);
  assign isDcmd     = (tagQ == DCMD_TAG);
  assign curTag     = tagQ;

endmodule

// File: rtl/qtask_walker.sv
module qtask_walker
  import qtw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NUM_SLOTS = 32,
  localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              cfgBigTask,
  input  logic              cfgWide,
  input  logic              cfgShortXfer,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [95:0]       memRspData,
  output logic              segValid,
  output logic [ADDR_W-1:0] segAddr,
  output logic [15:0]       segLen,
  output logic              segLast,
  input  logic              segReady,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [TAG_W-1:0]  errTag,
  output logic              attrValid,
  output logic [15:0]       taskBlkCnt,
  output logic [31:0]       taskBlkAddr,
  output logic [3:0]        taskCtx,
  output logic              taskDir,
  output logic              taskPrio,
  output logic              taskRelWr,
  output logic              taskForced,
  output logic              taskDataTag,
  output logic              taskQbar,
  output logic              taskIntr
);

  strobe_t          stb;
  hdr_t             hdr;
  logic             isDcmd;
  logic [TAG_W-1:0] curTag;
  attr_t            attr;

  qtw_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .hdr        (hdr),
    .isDcmd     (isDcmd),
    .segReady   (segReady),
    .segLastQ   (segLast),
    .stb        (stb),
    .memReqValid(memReqValid),
    .segValid   (segValid),
    .busy       (busy),
    .done       (done)
  );

  qtw_data #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .tagIn       (tagIn),
    .baseAddr    (baseAddr),
    .cfgBigTask  (cfgBigTask),
    .cfgWide     (cfgWide),
    .cfgShortXfer(cfgShortXfer),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .hdr         (hdr),
    .isDcmd      (isDcmd),
    .curTag      (curTag),
    .segAddr     (segAddr),
    .segLen      (segLen),
    .segLast     (segLast),
    .err         (err),
    .errTag      (errTag),
    .attrValid   (attrValid),
    .attr        (attr)
  );

  assign taskBlkCnt  = attr.blkCnt;
  assign taskBlkAddr = attr.blkAddr;
  assign taskCtx     = attr.ctx;
  assign taskDir     = attr.dir;
  assign taskPrio    = attr.prio;
  assign taskRelWr   = attr.relWr;
  assign taskForced  = attr.forced;
  assign taskDataTag = attr.dataTag;
  assign taskQbar    = attr.qbar;
  assign taskIntr    = attr.intr;

endmodule

// File: rtl/qtw_chk.sv
module qtw_chk #(
  parameter int ADDR_W    = 64,
  parameter int NUM_SLOTS = 32,
  localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memReqReady,
  input logic              memRspValid,
  input logic              segValid,
  input logic [ADDR_W-1:0] segAddr,
  input logic [15:0]       segLen,
  input logic              segLast,
  input logic              segReady,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [TAG_W-1:0]  curTag
);

  logic outstanding;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outstanding <= 1'b0;
    else if (memReqValid && memReqReady) outstanding <= 1'b1;
    else if (memRspValid) outstanding <= 1'b0;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);

  // R4
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid && $stable(segAddr) && $stable(segLen) && $stable(segLast));

  // R4
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    segValid && segReady && segLast |=> done && !segValid);

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R6
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);

  // R5
  dcmd_no_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && (curTag == TAG_W'(NUM_SLOTS - 1)) |-> !segValid);

endmodule

bind qtask_walker qtw_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .memReqReady(memReqReady),
  .memRspValid(memRspValid),
  .segValid   (segValid),
  .segAddr    (segAddr),
  .segLen     (segLen),
  .segLast    (segLast),
  .segReady   (segReady),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .curTag     (curTag)
);

// File: tb/test_qtask_walker.sv
`timescale 1ns/1ps
module test_qtask_walker;

  localparam int ADDR_W = 64;
  localparam int NSL    = 32;
  localparam int XBASE  = 'h800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  tagIn = '0;
  logic [63:0] baseAddr = '0;
  logic        cfgBigTask = 1'b0, cfgWide = 1'b0, cfgShortXfer = 1'b0;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [95:0] memRspData = '0;
  logic        segValid;
  logic [63:0] segAddr;
  logic [15:0] segLen;
  logic        segLast;
  logic        segReady = 1'b0;
  logic        busy, done, err, attrValid;
  logic [4:0]  errTag;
  logic [15:0] taskBlkCnt;
  logic [31:0] taskBlkAddr;
  logic [3:0]  taskCtx;
  logic        taskDir, taskPrio, taskRelWr, taskForced, taskDataTag, taskQbar, taskIntr;

  always #10 clk = ~clk;

  qtask_walker #(.ADDR_W(ADDR_W), .NUM_SLOTS(NSL)) i_qtask_walker (
    .clk(clk), .rstN(rstN), .start(start), .tagIn(tagIn), .baseAddr(baseAddr),
    .cfgBigTask(cfgBigTask), .cfgWide(cfgWide), .cfgShortXfer(cfgShortXfer),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .segValid(segValid), .segAddr(segAddr), .segLen(segLen), .segLast(segLast),
    .segReady(segReady), .busy(busy), .done(done), .err(err), .errTag(errTag),
    .attrValid(attrValid), .taskBlkCnt(taskBlkCnt), .taskBlkAddr(taskBlkAddr),
    .taskCtx(taskCtx), .taskDir(taskDir), .taskPrio(taskPrio), .taskRelWr(taskRelWr),
    .taskForced(taskForced), .taskDataTag(taskDataTag), .taskQbar(taskQbar),
    .taskIntr(taskIntr)
  );

  int nChk = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // descriptor memory model
  logic [7:0]  mem [0:4095];
  logic        pend = 1'b0;
  logic [11:0] pAddr = '0;
  int          lat = 0;
  int          cyc = 0;
  int          reqCnt = 0;
  logic [63:0] reqLog [0:15];

  function automatic logic [95:0] fetch(input logic [11:0] a);
    logic [95:0] d;
    for (int k = 0; k < 12; k++) d[8*k +: 8] = mem[12'(a + 12'(k))];
    return d;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memReqReady <= (cyc % 3) != 1;
    memRspValid <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= fetch(pAddr);
        pend        <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end
    if (memReqValid && memReqReady) begin
      pend   <= 1'b1;
      pAddr  <= memReqAddr[11:0];
      lat    <= cyc % 3;
      reqLog[reqCnt % 16] <= memReqAddr;
      reqCnt <= reqCnt + 1;
    end
  end

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[(a + k) & 'hFFF] = v[8*k +: 8];
  endtask

  task automatic put64(input int a, input logic [63:0] v);
    for (int k = 0; k < 8; k++) mem[(a + k) & 'hFFF] = v[8*k +: 8];
  endtask

  // expectations of the current scenario
  logic [63:0] expReq [0:7];
  logic [63:0] expAddr [0:3];
  logic [15:0] expLen [0:3];
  logic [63:0] expTask;

  // badKind: 0 none, 1 link invalid, 2 link wrong action, 3 second xfer wrong action,
  // 4 task wrong action, 5 second xfer invalid, 6 top slot with a real link,
  // 7 ordinary slot with a direct-command style link
  task automatic setup(input int tg, input int base, input bit big, input bit wide,
                       input bit shrt, input int nSeg, input int badKind);
    logic [31:0] tv;
    int tl, ll, xl, slot, la, lb, xa;
    logic [31:0] la32;
    tv = 32'(tg);
    tl = big ? 16 : 8;
    ll = wide ? 16 : 8;
    xl = !wide ? 8 : (shrt ? 12 : 16);
    slot = base + tg * (tl + ll);
    la = slot + tl;
    lb = XBASE + tg * 64;
    expTask = {32'hB000_0000 + tv, 16'h0100 + 16'(tg), tv[0], tv[1], tv[2], tv[3], tv[4],
               tv[3:0] ^ 4'hA, ~tv[0], (badKind == 4) ? 3'b110 : 3'b101, tv[1], 1'b1, 1'b1};
    put64(slot, expTask);
    if (big) put64(slot + 8, 64'h5A5A_5A5A_5A5A_5A5A);
    if (tg == NSL - 1 && badKind != 6) la32 = 32'h0000_0002;
    else if (badKind == 1) la32 = 32'h0000_0030;
    else if (badKind == 2) la32 = 32'h0000_0021;
    else if (badKind == 7) la32 = 32'h0000_0002;
    else la32 = 32'h0000_0031;
    put32(la, la32);
    if (wide) put64(la + 4, 64'(lb)); else put32(la + 4, 32'(lb));
    expReq[0] = 64'(base) + 64'(tg * (tl + ll));
    expReq[1] = 64'(la);
    for (int i = 0; i < nSeg; i++) begin
      logic [31:0] at;
      logic [63:0] sa;
      xa = lb + i * xl;
      sa = 64'hC000_0000 + 64'(tg << 12) + 64'(i << 8);
      if (wide) sa = sa | 64'h0000_00A5_0000_0000;
      expAddr[i] = sa;
      expLen[i]  = 16'h0200 + 16'(tg * 16) + 16'(i);
      at = {expLen[i], 10'b0, 3'b100, 1'b0, (i == nSeg - 1), 1'b1};
      if (i == 1 && badKind == 3) at[5:3] = 3'b101;
      if (i == 1 && badKind == 5) at[0] = 1'b0;
      put32(xa, at);
      if (wide) put64(xa + 4, sa); else put32(xa + 4, sa[31:0]);
      expReq[2 + i] = 64'(xa);
      if (i == nSeg - 1 && !wide) put32(xa + 8, 32'hFFFF_FFFF);
    end
    baseAddr = 64'(base);
    cfgBigTask = big;
    cfgWide = wide;
    cfgShortXfer = shrt;
  endtask

  task automatic runWalk(input int tg, input int nSeg, input int nReq, input bit expErr,
                         input bit expAttr, input string lbl);
    int rq0, got, waitN;
    bit seenDone, held;
    logic [63:0] hA;
    logic [15:0] hL;
    logic hLast;
    string rq;
    rq0 = reqCnt; got = 0; waitN = 0; seenDone = 0; held = 0;
    hA = '0; hL = '0; hLast = 1'b0;
    @(negedge clk);
    start = 1'b1;
    tagIn = 5'(tg);
    @(negedge clk);
    start = 1'b0;
    while (!seenDone && waitN < 3000) begin
      if (held) begin
        chk(segValid && segAddr == hA && segLen == hL && segLast == hLast,
            "R4", {lbl, " held segment"}, segAddr, hA);
      end
      segReady = ((waitN + tg) % 4) != 2;
      held = segValid && !segReady;
      hA = segAddr; hL = segLen; hLast = segLast;
      if (segValid && segReady) begin
        rq = expErr ? "R7" : "R4";
        if (got < nSeg) begin
          chk(segAddr == expAddr[got], rq, {lbl, " seg addr"}, segAddr, expAddr[got]);
          chk(segLen == expLen[got], rq, {lbl, " seg len"}, 64'(segLen), 64'(expLen[got]));
          chk(segLast == (!expErr && got == nSeg - 1), rq, {lbl, " seg last"},
              64'(segLast), 64'(!expErr && got == nSeg - 1));
        end
        got++;
      end
      if (done) seenDone = 1;
      @(negedge clk);
      waitN++;
    end
    segReady = 1'b0;
    chk(seenDone, "R9", {lbl, " walk finished"}, 64'(seenDone), 64'd1);
    chk(!done && !busy, "R9", {lbl, " done single cycle"}, 64'(done), 64'd0);
    chk(got == nSeg, expErr ? "R7" : "R4", {lbl, " segment count"}, 64'(got), 64'(nSeg));
    chk(err == expErr, expErr ? "R6" : "R5", {lbl, " err flag"}, 64'(err), 64'(expErr));
    if (expErr) chk(errTag == 5'(tg), "R6", {lbl, " err tag"}, 64'(errTag), 64'(tg));
    chk(reqCnt - rq0 == nReq, "R8", {lbl, " fetch count"}, 64'(reqCnt - rq0), 64'(nReq));
    for (int i = 0; i < nReq && i < 8; i++) begin
      rq = (i < 2) ? "R1" : "R3";
      chk(reqLog[(rq0 + i) % 16] == expReq[i], rq, {lbl, " fetch addr"},
          reqLog[(rq0 + i) % 16], expReq[i]);
    end
    chk(attrValid == expAttr, expAttr ? "R2" : "R10", {lbl, " attrValid"},
        64'(attrValid), 64'(expAttr));
    if (expAttr) begin
      chk({taskBlkAddr, taskBlkCnt, taskRelWr, taskQbar, taskPrio, taskDir, taskDataTag,
           taskCtx, taskForced} == {expTask[63:6]} && taskIntr == expTask[2],
          "R2", {lbl, " attributes"},
          {taskBlkAddr, taskBlkCnt, taskRelWr, taskQbar, taskPrio, taskDir, taskDataTag,
           taskCtx, taskForced, 3'b101, taskIntr, 2'b11}, expTask);
    end
  endtask

  initial begin
    #(20 * 200000);
    nChk++;
    nBad++;
    $display("FAIL R9 watchdog expired actual=%h expected=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !err && !attrValid && !memReqValid && !segValid, "R9",
        "reset state", {58'b0, busy, done, err, attrValid, memReqValid, segValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReqValid, "R9", "idle after reset", 64'(busy), 64'd0);

    // sweep: task size x addressing mode x tags, including the top slot (R5)
    for (int c = 0; c < 6; c++) begin
      bit big, wide, shrt;
      int base;
      big  = c[0];
      wide = (c / 2) != 0;
      shrt = (c / 2) == 2;
      base = 'h40 + c * 8;
      foreach (expReq[i]) expReq[i] = '0;
      for (int ti = 0; ti < 5; ti++) begin
        int tg, n;
        tg = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? 7 : (ti == 3) ? 30 : 31;
        n  = 1 + ((tg + c) % 3);
        if (tg == NSL - 1) begin
          setup(tg, base, big, wide, shrt, 0, 0);
          runWalk(tg, 0, 2, 1'b0, 1'b1, "R5 direct-command slot");
        end else begin
          setup(tg, base, big, wide, shrt, n, 0);
          runWalk(tg, n, 2 + n, 1'b0, 1'b1, "R3 sweep walk");
        end
      end
    end

    // R6 link faults
    setup(3, 'h40, 1'b0, 1'b0, 1'b0, 1, 1);
    runWalk(3, 0, 2, 1'b1, 1'b1, "R6 link invalid");
    setup(4, 'h40, 1'b1, 1'b1, 1'b0, 1, 2);
    runWalk(4, 0, 2, 1'b1, 1'b1, "R6 link wrong action");
    setup(5, 'h40, 1'b0, 1'b1, 1'b1, 1, 7);
    runWalk(5, 0, 2, 1'b1, 1'b1, "R6 ordinary slot with empty link");
    setup(31, 'h40, 1'b1, 1'b0, 1'b0, 1, 6);
    runWalk(31, 0, 2, 1'b1, 1'b1, "R6 top slot with real link");

    // R7 faults in the middle of a transfer list
    setup(2, 'h40, 1'b0, 1'b0, 1'b0, 3, 3);
    runWalk(2, 1, 4, 1'b1, 1'b1, "R7 second xfer wrong action");
    setup(9, 'h60, 1'b1, 1'b1, 1'b1, 3, 5);
    runWalk(9, 1, 4, 1'b1, 1'b1, "R7 second xfer invalid");

    // R10 task fault
    setup(6, 'h40, 1'b0, 1'b1, 1'b0, 2, 4);
    runWalk(6, 0, 1, 1'b1, 1'b0, "R10 task wrong action");

    // recovery: a clean walk after a fault clears err
    setup(6, 'h40, 1'b0, 1'b1, 1'b0, 2, 0);
    runWalk(6, 2, 4, 1'b0, 1'b1, "R9 clean walk after fault");

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule